// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt a small 8-bit processor core services next, and at what level the core then runs. Eleven maskable request lines each carry a two-bit software priority, and software programs these through a narrow register write port. The core's current two-bit interrupt level decides which requests may preempt the running code. A request gets through only when its software priority is strictly above that level. When several requests get through, the highest software priority wins, and the fixed hardware order breaks ties. Two events ignore the level: coming out of reset, and the software trap.

A decision is taken only in the cycle where the core marks the end of an instruction. The winner is reported one clock later as a single-cycle accept pulse. With it come a 16-bit vector address from the top 32 bytes of the address space and the level the core must load into its condition-code bits. The block keeps a four-entry stack of the levels that were interrupted. A return-from-interrupt strobe pops that stack and hands the previous level back to the core. Misuse of the stack, either a return with nothing saved or a fifth nested entry, raises an error pulse. Saving the core registers to memory is left to the core.

Top module: `nic_ctrl`

## Requirements
- R1: While `rst` is high, `accept`, `lvl_load` and `stk_err` are 0. On the first clock edge with `rst` low, the block issues a boot acceptance: one cycle later `accept` and `lvl_load` are 1, `vec_addr` is 16'hFFFE and `new_lvl` is 3. Nothing is pushed on the level stack.
- R2: A `trap_req` pulse is held pending. It is serviced at the next `instr_end` whatever `core_lvl` is, with `vec_addr` 16'hFFFC and `new_lvl` 3, and it wins over every maskable request.
- R3: A maskable request i is eligible only when its software priority is strictly greater than `core_lvl`. When `core_lvl` is 3, no maskable request is accepted.
- R4: Acceptances other than boot happen only on a clock edge where `instr_end` is 1. The outputs appear one cycle after that edge. With `instr_end` low, pending requests produce no `accept`.
- R5: Among eligible requests, the one with the highest software priority wins. On equal software priorities, the lower request index wins (index 0 has the highest hardware priority).
- R6: The vector address of maskable request i is 16'hFFFA - 2*i. Every vector is even and lies in 16'hFFE0..16'hFFFE.
- R7: On a maskable acceptance, `new_lvl` equals the software priority of the serviced request, and `lvl_load` is 1 together with `accept`.
- R8: Priority register k (`reg_addr` = k) holds the priority of request 4k+j in `reg_wdata` bits [2j+1:2j]. Every priority field resets to 3.
- R9: Each non-boot acceptance pushes `core_lvl`. An `iret` with a non-empty stack pops the most recent entry: one cycle later `lvl_load` is 1, `accept` is 0, and `new_lvl` is the popped level (last in, first out).
- R10: When `iret` and `instr_end` are high in the same cycle, the return is handled and the acceptance waits for a later `instr_end`.
- R11: An `iret` with an empty stack gives a one-cycle `stk_err` pulse, and `lvl_load` stays 0.
- R12: An acceptance attempted while four levels are already stacked is refused. `stk_err` pulses and `accept` stays 0, and the stored levels come back unchanged on the following returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 11 | Maskable request lines, bit 0 highest hardware priority |
| trap_req | input | 1 | Software trap strobe |
| instr_end | input | 1 | End of the current instruction |
| iret | input | 1 | Return-from-interrupt strobe |
| core_lvl | input | 2 | Current interrupt level of the core |
| reg_we | input | 1 | Priority register write enable |
| reg_addr | input | 2 | Priority register index |
| reg_wdata | input | 8 | Priority register write data, four 2-bit fields |
| accept | output | 1 | One-cycle pulse: a vector is to be fetched |
| lvl_load | output | 1 | One-cycle pulse: core must load `new_lvl` |
| vec_addr | output | 16 | Vector address of the accepted event |
| new_lvl | output | 2 | Level to load into the core |
| stk_err | output | 1 | One-cycle pulse on stack underflow or overflow |

## Verification
The hardest state to reach from the ports is a full level stack with a fifth request still waiting. Getting there takes four accepted nestings in a row with no return between them. The stimulus builds it from one request at priority 3 while `core_lvl` is stepped through a distinct sequence. The refused fifth acceptance is then checked, and the four returns must bring that sequence back in reverse. Around this, sweeps cover every request, priority and level, and every pair of requests with every pair of priorities, and the expected winner is computed from the eligibility and tie-break rules.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = lvl_t'(2'b11);
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] BOOT_VEC = 16'hFFFE;
  localparam logic [VEC_W-1:0] TRAP_VEC = 16'hFFFC;
  localparam logic [VEC_W-1:0] IRQ_VEC0 = 16'hFFFA;

  function automatic logic [VEC_W-1:0] irq_vec(input int idx);
    return IRQ_VEC0 - VEC_W'(2 * idx);
  endfunction
endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs #(
  parameter int N_IRQ  = 11,
  parameter int DATA_W = 8,
  parameter int RA_W   = 2,
  parameter logic [1:0] RST_PRIO = 2'b11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [RA_W-1:0]     addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*N_IRQ-1:0]  prio_flat
);
  localparam int FPR = DATA_W / 2;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_fld
    localparam int REG_IDX = i / FPR;
    localparam int FLD_IDX = i % FPR;
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_flat[2*i +: 2] <= RST_PRIO;
      end else if (we && (addr == RA_W'(REG_IDX))) begin
        prio_flat[2*i +: 2] <= wdata[2*FLD_IDX +: 2];
      end
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N_IRQ = 11,
  parameter int IDX_W = 4
) (
  input  logic [N_IRQ-1:0]    req,
  input  logic [2*N_IRQ-1:0]  prio_flat,
  input  logic [1:0]          cur_lvl,
  output logic                hit,
  output logic [IDX_W-1:0]    win_idx,
  output logic [1:0]          win_prio
);
  logic [N_IRQ-1:0] elig;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_elig
    assign elig[i] = req[i] && (prio_flat[2*i +: 2] > cur_lvl);
  end

  // Scan from lowest hardware priority upward; >= lets lower indices
  // take ties.
  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (elig[i] && (!hit || (prio_flat[2*i +: 2] >= win_prio))) begin
        hit      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_flat[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign top_idx = cnt - CNT_W'(1);
  assign dout    = mem[top_idx[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[cnt[PTR_W-1:0]] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int N_IRQ  = 11,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int RA_W   = $clog2((N_IRQ + DATA_W/2 - 1) / (DATA_W/2))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic               trap_req,
  input  logic               instr_end,
  input  logic               iret,
  input  logic [1:0]         core_lvl,
  input  logic               reg_we,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               accept,
  output logic               lvl_load,
  output logic [15:0]        vec_addr,
  output logic [1:0]         new_lvl,
  output logic               stk_err
);
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [2*N_IRQ-1:0] prio_flat;
  logic               arb_hit;
  logic [IDX_W-1:0]   arb_idx;
  logic [1:0]         arb_prio;
  logic               boot_pend;
  logic               trap_pend;
  logic               stk_empty;
  logic               stk_full;
  logic [1:0]         stk_top;
  logic               want;
  logic               do_push;
  logic               do_pop;

  nic_prio_regs #(.N_IRQ(N_IRQ), .DATA_W(DATA_W), .RA_W(RA_W)) prio_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .prio_flat(prio_flat)
  );

  nic_arbiter #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) arb_i (
    .req(irq_req), .prio_flat(prio_flat), .cur_lvl(core_lvl),
    .hit(arb_hit), .win_idx(arb_idx), .win_prio(arb_prio)
  );

  nic_lvl_stack #(.DEPTH(DEPTH), .W(LVL_W)) stk_i (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .din(core_lvl),
    .dout(stk_top), .empty(stk_empty), .full(stk_full)
  );

  assign want    = !boot_pend && !iret && instr_end && (trap_pend || arb_hit);
  assign do_push = want && !stk_full;
  assign do_pop  = !boot_pend && iret && !stk_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pend <= 1'b1;
      trap_pend <= 1'b0;
      accept    <= 1'b0;
      lvl_load  <= 1'b0;
      stk_err   <= 1'b0;
      vec_addr  <= '0;
      new_lvl   <= '0;
    end else begin
      accept   <= 1'b0;
      lvl_load <= 1'b0;
      stk_err  <= 1'b0;
      if (boot_pend) begin
        boot_pend <= 1'b0;
        accept    <= 1'b1;
        lvl_load  <= 1'b1;
        vec_addr  <= BOOT_VEC;
        new_lvl   <= LVL_TOP;
      end else if (iret) begin
        if (stk_empty) begin
          stk_err <= 1'b1;
        end else begin
          lvl_load <= 1'b1;
          new_lvl  <= stk_top;
        end
      end else if (want) begin
        if (stk_full) begin
          stk_err <= 1'b1;
        end else begin
          accept   <= 1'b1;
          lvl_load <= 1'b1;
          if (trap_pend) begin
            trap_pend <= 1'b0;
            vec_addr  <= TRAP_VEC;
            new_lvl   <= LVL_TOP;
          end else begin
            vec_addr <= irq_vec(int'(arb_idx));
            new_lvl  <= arb_prio;
          end
        end
      end
      if (trap_req) begin
        trap_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_ctrl_chk.sv
module nic_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_end,
  input logic        iret,
  input logic [1:0]  core_lvl,
  input logic        accept,
  input logic        lvl_load,
  input logic [15:0] vec_addr,
  input logic [1:0]  new_lvl,
  input logic        stk_err
);
  // R1
  boot_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (accept && vec_addr == 16'hFFFE && new_lvl == 2'd3));

  // R3
  lvl_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && vec_addr != 16'hFFFE && vec_addr != 16'hFFFC)
      |-> (new_lvl > $past(core_lvl)));

  // R4
  at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && vec_addr != 16'hFFFE) |-> ($past(instr_end) && !$past(iret)));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFE0));

  // R7
  load_with_acc_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> lvl_load);

  // R9
  restore_src_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_load && !accept) |-> $past(iret));

  // R12
  err_no_acc_chk: assert property (@(posedge clk) disable iff (rst)
    stk_err |-> (!accept && !lvl_load));
endmodule

bind nic_ctrl nic_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .instr_end(instr_end), .iret(iret),
  .core_lvl(core_lvl), .accept(accept), .lvl_load(lvl_load),
  .vec_addr(vec_addr), .new_lvl(new_lvl), .stk_err(stk_err)
);

// File: tb/nic_ctrl_tb_top.sv
module nic_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 11;
  localparam int WDOG  = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_IRQ-1:0]  irq_req = '0;
  logic              trap_req = 1'b0;
  logic              instr_end = 1'b0;
  logic              iret = 1'b0;
  logic [1:0]        core_lvl = '0;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic              accept;
  logic              lvl_load;
  logic [15:0]       vec_addr;
  logic [1:0]        new_lvl;
  logic              stk_err;

  int n_chk = 0;
  int n_err = 0;
  int cyc_cnt = 0;
  logic [1:0] shadow [N_IRQ];

  nic_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .trap_req(trap_req),
    .instr_end(instr_end), .iret(iret), .core_lvl(core_lvl),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .accept(accept), .lvl_load(lvl_load), .vec_addr(vec_addr),
    .new_lvl(new_lvl), .stk_err(stk_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WDOG) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_prio(input int idx, input logic [1:0] p);
    int rg;
    shadow[idx] = p;
    rg = idx / 4;
    reg_we   = 1'b1;
    reg_addr = 2'(rg);
    for (int f = 0; f < 4; f++) begin
      reg_wdata[2*f +: 2] = (rg*4 + f < N_IRQ) ? shadow[rg*4 + f] : 2'b00;
    end
    cyc();
    reg_we = 1'b0;
  endtask

  // one cycle with instr_end high; outputs sampled after the edge
  task automatic take(input logic [N_IRQ-1:0] rq, input logic [1:0] cl);
    irq_req = rq; core_lvl = cl; instr_end = 1'b1;
    cyc();
    instr_end = 1'b0; irq_req = '0;
  endtask

  task automatic do_iret();
    iret = 1'b1;
    cyc();
    iret = 1'b0;
  endtask

  function automatic logic [15:0] exp_vec(input int i);
    return 16'hFFFA - 16'(2*i);
  endfunction

  initial begin
    for (int i = 0; i < N_IRQ; i++) shadow[i] = 2'b11;
    @(negedge clk);
    cyc(); cyc();
    // R1: quiet during reset
    check("R1 acc in reset", 32'(accept), 0);
    check("R1 load in reset", 32'(lvl_load), 0);
    rst = 1'b0;
    cyc();
    check("R1 boot accept", 32'(accept), 1);
    check("R1 boot vec", 32'(vec_addr), 32'hFFFE);
    check("R1 boot lvl", 32'(new_lvl), 3);
    cyc();
    check("R1 boot single pulse", 32'(accept), 0);
    // R1: no push on boot -> iret underflows (R11)
    do_iret();
    check("R11 underflow err", 32'(stk_err), 1);
    check("R11 no load", 32'(lvl_load), 0);

    // R8: reset priority 3
    take(N_IRQ'(1) << 5, 2'd2);
    check("R8 reset prio accept", 32'(accept), 1);
    check("R8 reset prio lvl", 32'(new_lvl), 3);
    check("R6 vec idx5", 32'(vec_addr), 32'(exp_vec(5)));
    do_iret();
    check("R9 restore", 32'(new_lvl), 2);
    check("R9 restore load", 32'(lvl_load), 1);
    check("R9 restore no acc", 32'(accept), 0);

    // R4: no instr_end -> nothing
    irq_req = N_IRQ'(1) << 2; core_lvl = 2'd0;
    cyc(); cyc();
    check("R4 no end no accept", 32'(accept), 0);
    irq_req = '0;

    // R3 R6 R7 R8: single request sweep
    for (int i = 0; i < N_IRQ; i++) begin
      for (int p = 0; p < 4; p++) begin
        write_prio(i, 2'(p));
        for (int c = 0; c < 4; c++) begin
          take(N_IRQ'(1) << i, 2'(c));
          check("R3 eligibility", 32'(accept), 32'(p > c));
          if (p > c) begin
            check("R6 vector", 32'(vec_addr), 32'(exp_vec(i)));
            check("R7 new level", 32'(new_lvl), 32'(p));
            do_iret();
            check("R9 restore lvl", 32'(new_lvl), 32'(c));
          end
        end
      end
    end

    // R5: pair sweep at level 0
    for (int i = 0; i < N_IRQ; i++) begin
      for (int j = i + 1; j < N_IRQ; j++) begin
        for (int pi = 0; pi < 4; pi++) begin
          for (int pj = 0; pj < 4; pj++) begin
            int win;
            write_prio(i, 2'(pi));
            write_prio(j, 2'(pj));
            if (pi == 0 && pj == 0) win = -1;
            else if (pi >= pj) win = i;
            else win = j;
            take((N_IRQ'(1) << i) | (N_IRQ'(1) << j), 2'd0);
            check("R5 pair accept", 32'(accept), 32'(win >= 0));
            if (win >= 0) begin
              check("R5 pair winner", 32'(vec_addr), 32'(exp_vec(win)));
              check("R5 pair lvl", 32'(new_lvl), 32'((win == i) ? pi : pj));
              do_iret();
            end
            write_prio(i, 2'd0);
            write_prio(j, 2'd0);
          end
        end
      end
    end

    // R2: trap pending, ignores level, beats maskable
    write_prio(0, 2'd3);
    trap_req = 1'b1;
    cyc();
    trap_req = 1'b0;
    check("R2 trap waits end", 32'(accept), 0);
    take(N_IRQ'(1), 2'd3);
    check("R2 trap at lvl3", 32'(accept), 1);
    check("R2 trap vec", 32'(vec_addr), 32'hFFFC);
    check("R2 trap lvl", 32'(new_lvl), 3);
    do_iret();
    check("R2 trap restore", 32'(new_lvl), 3);
    trap_req = 1'b1; cyc(); trap_req = 1'b0;
    take(N_IRQ'(1), 2'd0);
    check("R2 trap beats irq", 32'(vec_addr), 32'hFFFC);
    do_iret();
    take(N_IRQ'(0), 2'd0);
    check("R2 trap cleared", 32'(accept), 0);

    // R10: iret wins over same-cycle instr_end
    take(N_IRQ'(1), 2'd1);
    check("R10 setup accept", 32'(accept), 1);
    irq_req = N_IRQ'(1); core_lvl = 2'd0; instr_end = 1'b1; iret = 1'b1;
    cyc();
    instr_end = 1'b0; iret = 1'b0; irq_req = '0;
    check("R10 no accept", 32'(accept), 0);
    check("R10 restore load", 32'(lvl_load), 1);
    check("R10 restore lvl", 32'(new_lvl), 1);
    take(N_IRQ'(1), 2'd0);
    check("R10 later accept", 32'(accept), 1);
    do_iret();

    // R12: four nestings, fifth refused, LIFO restore
    begin
      logic [1:0] seq [4];
      seq[0] = 2'd0; seq[1] = 2'd1; seq[2] = 2'd2; seq[3] = 2'd1;
      for (int k = 0; k < 4; k++) begin
        take(N_IRQ'(1), seq[k]);
        check("R12 nest accept", 32'(accept), 1);
      end
      take(N_IRQ'(1), 2'd0);
      check("R12 overflow err", 32'(stk_err), 1);
      check("R12 overflow no acc", 32'(accept), 0);
      for (int k = 3; k >= 0; k--) begin
        do_iret();
        check("R12 lifo level", 32'(new_lvl), 32'(seq[k]));
        check("R12 lifo load", 32'(lvl_load), 1);
      end
      do_iret();
      check("R11 empty again", 32'(stk_err), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule